// File: doc/BRIEF.md
# EEPROM Page Writer with Completion Polling

This block is a host-side bus master for a byte-wide electrically erasable memory that takes writes a page at a time. A single start command supplies a base address, a byte count and a polling mode. The block then takes bytes from a valid/ready source and loads each one with a write strobe whose setup, low and hold times are set in clock cycles. It keeps successive write-strobe falling edges close enough together that the device holds its page-load window open. When the page is loaded, it reads the device back until the internal programming cycle is finished.

Two ways of detecting completion are offered. In data mode, the last written address is read until bit 7 of the read value matches bit 7 of the byte last written. In toggle mode, successive reads are compared until bit 6 stops changing. A request that would run past the end of a 64-byte page is shortened at the boundary. If the byte source stalls long enough that the page window would close, the writer closes the page itself, waits for completion and then carries on. A polling timeout stops a write that never completes, for example one the device silently refused, from hanging the block.

Top module: `eeprom_page_writer`

## Requirements
- R1: A start pulse while idle begins a transfer. `busy` stays high until the cycle in which `done` is high. `done` is high for exactly one cycle. At that cycle `bytes_written` gives the number of bytes loaded.
- R2: Write strobes and read strobes never overlap. During a byte load `ee_ce_n` is low, `ee_oe_n` is high and `ee_dout_en` is high. `ee_we_n` is low for exactly PULSE_CYC cycles. It is preceded by SETUP_CYC setup cycles and followed by HOLD_CYC hold cycles. During a poll read `ee_ce_n` and `ee_oe_n` are low, `ee_we_n` is high and `ee_dout_en` is low.
- R3: The number of bytes loaded is the smaller of `byte_count` and 64 minus address bits 5:0 of `base_addr`. Every load uses the same address bits 14:6 as `base_addr`. A count of 0 ends the transfer with no load.
- R4: Within one page, any two successive falling edges of `ee_we_n` are fewer than WINDOW_CYC cycles apart.
- R5: If the byte source stalls so that the next load could not begin inside the window, the writer closes the page and polls to completion. It then resumes with the remaining bytes at the following addresses.
- R6: With `poll_mode`=0, the writer reads the last loaded address until bit 7 of `ee_din` equals bit 7 of the last loaded byte.
- R7: With `poll_mode`=1, the writer declares completion when bit 6 of `ee_din` is the same in two successive reads of one polling phase.
- R8: If a polling phase lasts POLL_LIMIT cycles without completion, the transfer ends: `done` pulses and `timeout` rises. `timeout` stays high until the next start.
- R9: During reset, and afterwards until a start, all three strobes are high, `ee_dout_en` is low, and `busy`, `done`, `timeout` and `in_ready` are low.
- R10: `in_ready` is high only while a transfer is waiting for a byte. Accepted bytes are loaded in order to consecutive addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (taken while idle) |
| base_addr | input | ADDR_W | First byte address |
| byte_count | input | PAGE_W+1 | Requested bytes, 0 to 64 |
| poll_mode | input | 1 | 0: bit-7 data compare, 1: bit-6 toggle |
| in_valid | input | 1 | Source byte valid |
| in_data | input | DATA_W | Source byte |
| in_ready | output | 1 | Writer accepts a byte this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| timeout | output | 1 | Last transfer ended without seeing completion |
| bytes_written | output | PAGE_W+1 | Bytes loaded by the last transfer |
| ee_ce_n | output | 1 | Memory chip enable, active low |
| ee_oe_n | output | 1 | Memory output enable, active low |
| ee_we_n | output | 1 | Memory write enable, active low |
| ee_addr | output | ADDR_W | Memory address bus |
| ee_dout | output | DATA_W | Data driven to the memory |
| ee_dout_en | output | 1 | Drive enable for `ee_dout` |
| ee_din | input | DATA_W | Data read from the memory |

## Verification
The bound checker checks these rules on every cycle:
- write and read strobes never overlap;
- data is driven only while the output enable is high;
- every load address stays in the starting page;
- falling edges of write enable stay inside the load window;
- `done` lasts one cycle and the strobes rest while idle.

Several behaviours need the bench's memory model, which complements bit 7 and toggles bit 6 while it programs:
- that completion is not declared early in either polling mode;
- that page clipping writes the right bytes and no others;
- that a stall splits the transfer into two programming cycles;
- that a device that never finishes leads to a timeout.

// File: rtl/epw_pkg.sv
// Shared types for the EEPROM page writer.
package epw_pkg;
    // Controller phases; write phases first, then the polling loop.
    typedef enum logic [3:0] {
        S_IDLE,
        S_WAIT,
        S_WSETUP,
        S_WPULSE,
        S_WHOLD,
        S_RSETUP,
        S_RPULSE,
        S_RREST,
        S_FINISH
    } epw_state_t;
endpackage

// File: rtl/epw_counter.sv
// Saturating up counter with synchronous clear.
// Assumes clear has priority over increment; holds at all-ones.
module epw_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    // Count cycles, restart on clear, stop at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else if (inc && (q != '1)) q <= q + 1'b1;
    end
endmodule

// File: rtl/epw_page_clip.sv
// Shortens a requested byte count so that a transfer ends at the page edge.
// Assumes count is at most one page (2**PAGE_W).
module epw_page_clip #(
    parameter int PAGE_W = 6,
    localparam int CNT_W = PAGE_W + 1
) (
    input  logic [PAGE_W-1:0] offset,
    input  logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  len
);
    localparam logic [CNT_W-1:0] PAGE_BYTES = CNT_W'(1 << PAGE_W);

    logic [CNT_W-1:0] room;

    // Room left in the page, then the smaller of room and request.
    always_comb begin
        room = PAGE_BYTES - CNT_W'(offset);
        len  = (count > room) ? room : count;
    end
endmodule

// File: rtl/eeprom_page_writer.sv
// Host-side page writer for a byte-wide page-write EEPROM.
// Loads up to one page of bytes from a valid/ready stream with timed
// strobes, then polls the device (bit-7 data compare or bit-6 toggle)
// until programming ends or a timeout expires. Assumes the strobe
// outputs are retimed or decoded glitch-free at the pads, and that
// WINDOW_CYC exceeds SETUP_CYC + 1.
module eeprom_page_writer
    import epw_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int PAGE_W     = 6,
    parameter int SETUP_CYC  = 2,
    parameter int PULSE_CYC  = 4,
    parameter int HOLD_CYC   = 2,
    parameter int WINDOW_CYC = 25000,
    parameter int POLL_LIMIT = 2500000,
    localparam int CNT_W     = PAGE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              poll_mode,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [CNT_W-1:0]  bytes_written,
    output logic              ee_ce_n,
    output logic              ee_oe_n,
    output logic              ee_we_n,
    output logic [ADDR_W-1:0] ee_addr,
    output logic [DATA_W-1:0] ee_dout,
    output logic              ee_dout_en,
    input  logic [DATA_W-1:0] ee_din
);
    localparam int PH_W     = $clog2(SETUP_CYC + PULSE_CYC + HOLD_CYC + 1);
    localparam int GAP_W    = $clog2(WINDOW_CYC + 1);
    localparam int TMO_W    = $clog2(POLL_LIMIT + 1);
    localparam int CLOSE_AT = WINDOW_CYC - 1 - SETUP_CYC;
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    epw_state_t        st, st_nxt;
    logic [ADDR_W-1:0] cur_addr, last_addr;
    logic [CNT_W-1:0]  remaining, written, clip_len;
    logic [DATA_W-1:0] wr_data, last_data;
    logic              mode_q, prev_tog, have_prev, timeout_q, page_open;
    logic [PH_W-1:0]   ph_q, ph_last;
    logic [GAP_W-1:0]  gap_q;
    logic [TMO_W-1:0]  tmo_q;
    logic              ph_end, polling, must_close, poll_ok, tmo_hit;

    epw_page_clip #(.PAGE_W(PAGE_W)) u_clip (
        .offset (base_addr[PAGE_W-1:0]),
        .count  (byte_count),
        .len    (clip_len)
    );

    // Phase timer: restarts on every state change.
    epw_counter #(.W(PH_W)) u_ph (
        .clk(clk), .rst_n(rst_n), .clr(st_nxt != st), .inc(1'b1), .q(ph_q)
    );

    // Cycles since the latest write-enable falling edge.
    epw_counter #(.W(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .clr(st == S_WSETUP && ph_end),
        .inc(1'b1), .q(gap_q)
    );

    // Cycles spent in the current polling phase.
    epw_counter #(.W(TMO_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .clr(!polling), .inc(1'b1), .q(tmo_q)
    );

    // Length of the current timed phase, minus one.
    always_comb begin
        case (st)
            S_WSETUP, S_RSETUP: ph_last = PH_W'(SETUP_CYC - 1);
            S_WPULSE, S_RPULSE: ph_last = PH_W'(PULSE_CYC - 1);
            S_WHOLD,  S_RREST:  ph_last = PH_W'(HOLD_CYC - 1);
            default:            ph_last = '0;
        endcase
    end

    // Phase end, window lookahead and completion decisions.
    always_comb begin
        ph_end     = (ph_q == ph_last);
        polling    = (st == S_RSETUP) || (st == S_RPULSE) || (st == S_RREST);
        must_close = page_open && (gap_q >= GAP_W'(CLOSE_AT));
        tmo_hit    = (tmo_q >= TMO_W'(POLL_LIMIT - 1));
        if (mode_q) poll_ok = have_prev && (ee_din[TOG_BIT] == prev_tog);
        else        poll_ok = (ee_din[POLL_BIT] == last_data[POLL_BIT]);
    end

    // Next-state selection.
    always_comb begin
        st_nxt = st;
        case (st)
            S_IDLE:   if (start) st_nxt = (clip_len == '0) ? S_FINISH : S_WAIT;
            S_WAIT:   if (must_close) st_nxt = S_RSETUP;
                      else if (in_valid) st_nxt = S_WSETUP;
            S_WSETUP: if (ph_end) st_nxt = S_WPULSE;
            S_WPULSE: if (ph_end) st_nxt = S_WHOLD;
            S_WHOLD:  if (ph_end) st_nxt = (remaining == CNT_W'(1)) ? S_RSETUP : S_WAIT;
            S_RSETUP: if (tmo_hit) st_nxt = S_FINISH;
                      else if (ph_end) st_nxt = S_RPULSE;
            S_RPULSE: if (ph_end && poll_ok)
                          st_nxt = (remaining == '0) ? S_FINISH : S_WAIT;
                      else if (tmo_hit) st_nxt = S_FINISH;
                      else if (ph_end) st_nxt = S_RREST;
            S_RREST:  if (tmo_hit) st_nxt = S_FINISH;
                      else if (ph_end) st_nxt = S_RSETUP;
            S_FINISH: st_nxt = S_IDLE;
            default:  st_nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nxt;
    end

    // Transfer bookkeeping: addresses, counts, saved byte, poll history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            last_addr <= '0;
            remaining <= '0;
            written   <= '0;
            wr_data   <= '0;
            last_data <= '0;
            mode_q    <= 1'b0;
            prev_tog  <= 1'b0;
            have_prev <= 1'b0;
            timeout_q <= 1'b0;
            page_open <= 1'b0;
        end else begin
            if (st == S_IDLE && start) begin
                cur_addr  <= base_addr;
                remaining <= clip_len;
                written   <= '0;
                mode_q    <= poll_mode;
                timeout_q <= 1'b0;
            end
            if (st == S_WAIT && !must_close && in_valid) wr_data <= in_data;
            if (st == S_WPULSE) page_open <= 1'b1;
            if (st == S_RSETUP) page_open <= 1'b0;
            if (st == S_WHOLD && ph_end) begin
                last_data <= wr_data;
                last_addr <= cur_addr;
                cur_addr  <= cur_addr + ADDR_W'(1);
                remaining <= remaining - CNT_W'(1);
                written   <= written + CNT_W'(1);
            end
            if (st == S_WAIT || st == S_WHOLD) have_prev <= 1'b0;
            if (st == S_RPULSE && ph_end) begin
                prev_tog  <= ee_din[TOG_BIT];
                have_prev <= 1'b1;
            end
            if (polling && st_nxt == S_FINISH && !(st == S_RPULSE && ph_end && poll_ok))
                timeout_q <= 1'b1;
        end
    end

    // Strobe and handshake decode from the state register.
    always_comb begin
        ee_ce_n       = !(st == S_WSETUP || st == S_WPULSE || st == S_WHOLD ||
                          st == S_RSETUP || st == S_RPULSE);
        ee_we_n       = (st != S_WPULSE);
        ee_oe_n       = (st != S_RPULSE);
        ee_dout_en    = (st == S_WSETUP || st == S_WPULSE || st == S_WHOLD);
        ee_dout       = wr_data;
        ee_addr       = polling ? last_addr : cur_addr;
        in_ready      = (st == S_WAIT) && !must_close;
        busy          = (st != S_IDLE);
        done          = (st == S_FINISH);
        timeout       = timeout_q;
        bytes_written = written;
    end
endmodule

// File: rtl/epw_checker.sv
// Protocol checker for eeprom_page_writer, attached by bind.
// Tracks the start page and the distance between write-enable falls.
module epw_checker #(
    parameter int ADDR_W     = 15,
    parameter int PAGE_W     = 6,
    parameter int WINDOW_CYC = 25000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              timeout,
    input logic [ADDR_W-1:0] base_addr,
    input logic              ee_ce_n,
    input logic              ee_oe_n,
    input logic              ee_we_n,
    input logic [ADDR_W-1:0] ee_addr,
    input logic              ee_dout_en
);
    localparam int WC_W = $clog2(WINDOW_CYC + 2);

    logic [ADDR_W-PAGE_W-1:0] pg;
    logic                     we_q, armed;
    logic [WC_W-1:0]          wcnt;
    logic                     we_fall;

    assign we_fall = we_q && !ee_we_n;

    // Record the page of each transfer and time the write-enable falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg    <= '0;
            we_q  <= 1'b1;
            armed <= 1'b0;
            wcnt  <= '0;
        end else begin
            we_q <= ee_we_n;
            if (start && !busy) pg <= base_addr[ADDR_W-1:PAGE_W];
            if (we_fall) begin
                wcnt  <= WC_W'(1);
                armed <= 1'b1;
            end else begin
                if (!ee_oe_n || (start && !busy)) armed <= 1'b0;
                if (wcnt != '1) wcnt <= wcnt + 1'b1;
            end
        end
    end

    // R2: write and read strobes never overlap
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ee_we_n && !ee_oe_n));

    // R2: data is driven only while output enable is high
    a_r2_drive_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ee_dout_en |-> ee_oe_n);

    // R3: each load stays in the starting page
    a_r3_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_we_n |-> (ee_addr[ADDR_W-1:PAGE_W] == pg));

    // R4: write-enable falls inside one page stay inside the window
    a_r4_load_window: assert property (@(posedge clk) disable iff (!rst_n)
        (we_fall && armed) |-> (wcnt < WC_W'(WINDOW_CYC)));

    // R1: done lasts a single cycle
    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a raised timeout means the transfer has ended
    a_r8_timeout_end: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (!busy || done));

    // R9: strobes rest while idle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ee_ce_n && ee_we_n && ee_oe_n && !ee_dout_en));
endmodule

bind eeprom_page_writer epw_checker #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WINDOW_CYC(WINDOW_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .timeout(timeout), .base_addr(base_addr), .ee_ce_n(ee_ce_n),
    .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n), .ee_addr(ee_addr),
    .ee_dout_en(ee_dout_en)
);

// File: tb/eeprom_page_writer_bench.sv
module eeprom_page_writer_bench;
    localparam int SETUP = 1, PULSE = 2, HOLD = 1, WIN = 40, PLIM = 3000;
    localparam int PROG  = 300;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, poll_mode = 1'b0, in_valid = 1'b0;
    logic [14:0] base_addr = '0;
    logic [6:0]  byte_count = '0;
    logic [7:0]  in_data = '0;
    logic in_ready, busy, done, timeout;
    logic [6:0] bytes_written;
    logic ee_ce_n, ee_oe_n, ee_we_n, ee_dout_en;
    logic [14:0] ee_addr;
    logic [7:0]  ee_dout, ee_din;

    always #2 clk = ~clk;

    eeprom_page_writer #(
        .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD),
        .WINDOW_CYC(WIN), .POLL_LIMIT(PLIM)
    ) u_eeprom_page_writer (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .byte_count(byte_count), .poll_mode(poll_mode), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .busy(busy), .done(done),
        .timeout(timeout), .bytes_written(bytes_written), .ee_ce_n(ee_ce_n),
        .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n), .ee_addr(ee_addr),
        .ee_dout(ee_dout), .ee_dout_en(ee_dout_en), .ee_din(ee_din)
    );

    // ---------------- behavioural memory model ----------------
    logic [7:0] emem [0:1023];
    logic [7:0] pend [0:63];
    logic       pv   [0:63];
    logic [8:0] m_page;
    logic [7:0] m_last;
    logic m_loading = 1'b0, m_prog = 1'b0, m_tog = 1'b0, stuck = 1'b0;
    logic we_p = 1'b1, oe_p = 1'b1;
    int cyc = 0, last_fall = 0, pcnt = 0, wlow = 0;
    int progs = 0, wefalls = 0;
    int v_excl = 0, v_drive = 0, v_page = 0, v_win = 0, v_pulse = 0, v_busy = 0, v_ready = 0;

    initial begin
        for (int i = 0; i < 1024; i++) emem[i] = 8'hFF;
        for (int i = 0; i < 64; i++) pv[i] = 1'b0;
    end

    // Read data: status pattern while programming, stored data otherwise.
    always_comb begin
        if (m_prog) ee_din = {~m_last[7], m_tog, 6'b0};
        else        ee_din = emem[ee_addr[9:0]];
    end

    // Per-clock model of the device and protocol watch.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_loading <= 1'b0; m_prog <= 1'b0; we_p <= 1'b1; oe_p <= 1'b1;
        end else begin
            we_p <= ee_we_n;
            oe_p <= ee_oe_n;
            if (!ee_we_n && !ee_oe_n) v_excl++;
            if (ee_dout_en && !ee_oe_n) v_drive++;
            if (in_ready && !busy) v_ready++;
            if (!ee_we_n && (ee_ce_n || ee_dout_en == 1'b0)) v_drive++;
            if (!ee_we_n && we_p) begin
                wefalls++;
                wlow = 1;
                if (m_prog) v_busy++;
                if (m_loading && (cyc - last_fall) >= WIN) v_win++;
                if (m_loading && ee_addr[14:6] != m_page) v_page++;
                if (!m_loading) m_page <= ee_addr[14:6];
                pend[ee_addr[5:0]] <= ee_dout;
                pv[ee_addr[5:0]]   <= 1'b1;
                m_last    <= ee_dout;
                m_loading <= 1'b1;
                last_fall <= cyc;
            end else if (m_loading && ((cyc - last_fall) >= WIN || (!ee_oe_n && oe_p))) begin
                m_loading <= 1'b0; m_prog <= 1'b1; pcnt <= 0; progs++;
            end
            if (!ee_we_n && !we_p) wlow++;
            if (ee_we_n && !we_p && wlow != PULSE) v_pulse++;
            if (ee_oe_n && !oe_p) m_tog <= ~m_tog;
            if (m_prog) begin
                if (pcnt >= PROG && !stuck) begin
                    for (int k = 0; k < 64; k++) begin
                        if (pv[k]) emem[{m_page[3:0], 6'(k)}] <= pend[k];
                        pv[k] <= 1'b0;
                    end
                    m_prog <= 1'b0;
                end else pcnt <= pcnt + 1;
            end
        end
    end

    // ---------------- checking ----------------
    int total = 0, bad = 0;
    bit ended = 0;
    logic [7:0] tx [$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic start_xfer(input logic [14:0] b, input logic [6:0] c, input logic m);
        @(negedge clk);
        base_addr = b; byte_count = c; poll_mode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed(input int n, input int stall_at, input int stall_len);
        for (int i = 0; i < n; i++) begin
            if (i == stall_at) repeat (stall_len) @(negedge clk);
            in_data = tx[i]; in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic wait_done(output logic to, output int w, output logic prog_at_done);
        while (!done) @(negedge clk);
        to = timeout; w = int'(bytes_written); prog_at_done = m_prog;
        @(negedge clk);
    endtask

    task automatic fill(input int n, input int seed, input logic last7);
        tx.delete();
        for (int i = 0; i < n; i++) tx.push_back(8'((i * 37 + seed) & 8'h7F));
        if (n > 0) tx[n-1][7] = last7;
    endtask

    task automatic mem_chk(input string req, input int base, input int n);
        int errs = 0;
        for (int i = 0; i < n; i++)
            if (emem[(base + i) & 1023] != tx[i]) errs++;
        chk(errs == 0, req, "bytes stored", errs, 0);
    endtask

    // Runs one transfer with an expected length and checks its outcome.
    task automatic run(input string req, input int base, input int cnt, input logic m,
                       input int exp_len, input int stall_at, input int stall_len,
                       input int exp_progs, input logic last7);
        logic to, pd; int w; int p0, f0;
        fill(exp_len, base, last7);
        p0 = progs; f0 = wefalls;
        start_xfer(15'(base), 7'(cnt), m);
        chk(busy == 1'b1, "R1", "busy after start", int'(busy), 1);
        feed(exp_len, stall_at, stall_len);
        wait_done(to, w, pd);
        chk(w == exp_len, req, "bytes_written", w, exp_len);
        chk(to == 1'b0, req, "timeout", int'(to), 0);
        chk(pd == 1'b0, req, "device idle at done", int'(pd), 0);
        chk(busy == 1'b0, "R1", "idle after done", int'(busy), 0);
        chk(wefalls - f0 == exp_len, "R10", "load count", wefalls - f0, exp_len);
        chk(progs - p0 == exp_progs, req, "programming cycles", progs - p0, exp_progs);
        mem_chk(req, base, exp_len);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic to, pd; int w; int f0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk({ee_ce_n, ee_we_n, ee_oe_n} == 3'b111, "R9", "strobes in reset", int'({ee_ce_n, ee_we_n, ee_oe_n}), 7);
        chk({busy, done, timeout, in_ready, ee_dout_en} == 5'b0, "R9", "flags in reset",
            int'({busy, done, timeout, in_ready, ee_dout_en}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({ee_ce_n, ee_we_n, ee_oe_n, busy} == 4'b1110, "R9", "idle after reset",
            int'({ee_ce_n, ee_we_n, ee_oe_n, busy}), 14);

        // R6: data polling, last bit 7 low then high
        run("R6", 'h105, 8, 1'b0, 8, -1, 0, 1, 1'b0);
        run("R6", 'h1A0, 3, 1'b0, 3, -1, 0, 1, 1'b1);
        // R7: toggle polling
        run("R7", 'h200, 5, 1'b1, 5, -1, 0, 1, 1'b0);
        // R3: request clipped at the page edge (offset 60, 10 requested -> 4)
        run("R3", 'h03C, 10, 1'b0, 4, -1, 0, 1, 1'b1);
        chk(emem['h040] == 8'hFF, "R3", "byte past page untouched", int'(emem['h040]), 255);
        // R3/R10: a full page
        run("R10", 'h140, 64, 1'b0, 64, -1, 0, 1, 1'b1);
        // R3: zero count loads nothing
        f0 = wefalls;
        start_xfer(15'h080, 7'd0, 1'b0);
        wait_done(to, w, pd);
        chk(w == 0 && wefalls == f0, "R3", "zero count loads", wefalls - f0 + w, 0);
        // R5: stall longer than the window splits the page
        run("R5", 'h2C0, 6, 1'b0, 6, 3, 100, 2, 1'b0);
        // R8: device never finishes
        stuck = 1'b1;
        fill(2, 7, 1'b0);
        start_xfer(15'h300, 7'd2, 1'b1);
        feed(2, -1, 0);
        wait_done(to, w, pd);
        chk(to == 1'b1, "R8", "timeout raised", int'(to), 1);
        chk(w == 2, "R8", "bytes_written on timeout", w, 2);
        repeat (3) @(negedge clk);
        chk(timeout == 1'b1 && busy == 1'b0, "R8", "timeout held idle", int'({timeout, busy}), 2);
        stuck = 1'b0;
        repeat (5) @(negedge clk);
        start_xfer(15'h320, 7'd2, 1'b0);
        chk(timeout == 1'b0, "R8", "timeout cleared by start", int'(timeout), 0);
        fill(2, 'h320, 1'b1);
        feed(2, -1, 0);
        wait_done(to, w, pd);
        chk(to == 1'b0 && w == 2, "R8", "clean run after timeout", int'(to), 0);
        mem_chk("R8", 'h320, 2);

        // Aggregated per-clock protocol watch
        chk(v_excl == 0, "R2", "strobe overlap cycles", v_excl, 0);
        chk(v_drive == 0, "R2", "drive/enable violations", v_drive, 0);
        chk(v_pulse == 0, "R2", "write pulse width errors", v_pulse, 0);
        chk(v_page == 0, "R3", "page crossings", v_page, 0);
        chk(v_win == 0, "R4", "window violations", v_win, 0);
        chk(v_busy == 0, "R5", "loads while programming", v_busy, 0);
        chk(v_ready == 0, "R10", "ready while idle", v_ready, 0);
        finish_run();
    end
endmodule